// File: doc/BRIEF.md
# Coprocessor Availability Fault Checker

This block keeps a 32-bit legacy processor control word and judges each legacy instruction handed to it. For each instruction it decides whether the instruction may run, must raise a device-not-available fault, or must be intercepted so that native software can emulate it. The decision looks at four control bits: protected-mode enable, monitor-coprocessor, emulation and task-switched. The control word also has an extension-type bit, which always reads as one.

The upstream decoder presents one instruction-class code per cycle, qualified by a valid strobe. One cycle later the block returns a registered result: a valid flag, a two-bit fault code, and read data for move-from-control instructions. A legacy move-to-control instruction is always intercepted and never writes the word. Native-side code changes the word through a separate write port, and that write has no effect outside the word itself.

Top module: `cop_avail_checker`

## Requirements
- R1: While reset is high and on the first cycle after it, all outputs are 0. Reset loads the control word with 32'h0000_0010, so a move-from-control issued right after reset returns 32'h0000_0010.
- R2: `res_valid` is high exactly one cycle after a cycle with `insn_valid` high. The fault codes are 2'b00 none, 2'b01 device-not-available and 2'b10 intercept. The code 2'b11 never appears.
- R3: Class 3'd1 (escape/floating point) gives fault code 2'b01 when word bit 2 (emulation) or bit 3 (task-switched) is 1. Otherwise it gives 2'b00.
- R4: Class 3'd2 (packed-integer/SIMD) gives 2'b10 when bit 2 is 1, even if bit 3 is also 1. It gives 2'b01 when bit 2 is 0 and bit 3 is 1. Otherwise it gives 2'b00.
- R5: Class 3'd3 (wait) gives 2'b01 only when bit 3 and bit 1 (monitor-coprocessor) are both 1. Otherwise it gives 2'b00.
- R6: Class 3'd4 (move-to-control) always gives 2'b10 and leaves the control word unchanged.
- R7: Class 3'd5 (move-from-control) gives 2'b00 and returns the whole control word on `res_rdata` with bit 4 forced to 1. For every other result `res_rdata` is 0.
- R8: A native write (`nat_wr_en`) replaces the whole stored word and raises no output. With no instruction present, all outputs stay 0.
- R9: A native write in the same cycle as a checked instruction does not affect that instruction. It takes effect from the next instruction on.
- R10: Classes 3'd0, 3'd6 and 3'd7 never fault and return zero read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | An instruction class is presented this cycle |
| insn_cls | input | 3 | Instruction class code |
| nat_wr_en | input | 1 | Native-side write of the control word |
| nat_wr_data | input | 32 | New control word value |
| res_valid | output | 1 | Result for the instruction of the previous cycle |
| res_fault | output | 2 | Fault code |
| res_rdata | output | 32 | Move-from-control read data |

## Verification
The checker module verifies on every cycle the properties that follow from a single instruction. These are the one-cycle valid timing, the absence of code 2'b11, the intercept on every move-to-control and the stability of the word across it, the intercept taking precedence for packed-integer instructions when emulation is set, and the extension-type bit in read data. The interaction between a native write and an instruction in the same cycle, the full fault table over mixed control-word values, and the reset contents of the word can only be shown by the bench's scenarios, where a behavioural model tracks the word over time.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  localparam int WORD_W     = 32;
  localparam int CLS_W      = 3;
  localparam int BIT_PROT   = 0;
  localparam int BIT_MONCOP = 1;
  localparam int BIT_EMUL   = 2;
  localparam int BIT_TASKSW = 3;
  localparam int BIT_EXTTYP = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER  = 3'd0,
    CLS_FLOAT  = 3'd1,
    CLS_SIMD   = 3'd2,
    CLS_WAIT   = 3'd3,
    CLS_MOVTO  = 3'd4,
    CLS_MOVFR  = 3'd5,
    CLS_RSVD6  = 3'd6,
    CLS_RSVD7  = 3'd7
  } insn_cls_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_DNA   = 2'b01,
    FLT_INTCP = 2'b10
  } fault_e;

  typedef struct packed {
    logic monitor;
    logic emulate;
    logic task_sw;
  } ctl_view_t;
endpackage

// File: rtl/cpa_word_reg.sv
module cpa_word_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)        word <= RST_VAL;
    else if (wr_en) word <= wr_data;
  end
endmodule

// File: rtl/cpa_decide.sv
module cpa_decide
  import cpa_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int FORCE_BIT = BIT_EXTTYP
) (
  input  logic            valid,
  input  logic [CLS_W-1:0] cls,
  input  logic [W-1:0]    word,
  output fault_e          fault,
  output logic            rd_sel,
  output logic [W-1:0]    rd_word
);
  localparam logic [W-1:0] FORCE_MASK = W'(1) << FORCE_BIT;

  ctl_view_t cv;
  insn_cls_e c;

  always_comb begin
    cv.monitor = word[BIT_MONCOP];
    cv.emulate = word[BIT_EMUL];
    cv.task_sw = word[BIT_TASKSW];
    c          = insn_cls_e'(cls);
  end

  always_comb begin
    fault  = FLT_NONE;
    rd_sel = 1'b0;
    if (valid) begin
      unique case (c)
        CLS_FLOAT: if (cv.emulate || cv.task_sw) fault = FLT_DNA;
        CLS_SIMD: begin
          if (cv.emulate)      fault = FLT_INTCP;
          else if (cv.task_sw) fault = FLT_DNA;
        end
        CLS_WAIT:  if (cv.task_sw && cv.monitor) fault = FLT_DNA;
        CLS_MOVTO: fault = FLT_INTCP;
        CLS_MOVFR: rd_sel = 1'b1;
        default:   fault = FLT_NONE;
      endcase
    end
  end

  assign rd_word = word | FORCE_MASK;
endmodule

// File: rtl/cpa_result_reg.sv
module cpa_result_reg
  import cpa_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  fault_e       fault,
  input  logic         rd_sel,
  input  logic [W-1:0] rd_word,
  output logic         res_valid,
  output logic [1:0]   res_fault,
  output logic [W-1:0] res_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_fault <= FLT_NONE;
      res_rdata <= '0;
    end else begin
      res_valid <= valid;
      res_fault <= fault;
      res_rdata <= rd_sel ? rd_word : '0;
    end
  end
endmodule

// File: rtl/cop_avail_checker.sv
module cop_avail_checker
  import cpa_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int CW = CLS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_valid,
  input  logic [CW-1:0] insn_cls,
  input  logic          nat_wr_en,
  input  logic [W-1:0]  nat_wr_data,
  output logic          res_valid,
  output logic [1:0]    res_fault,
  output logic [W-1:0]  res_rdata
);
  localparam logic [W-1:0] RST_WORD = W'(1) << BIT_EXTTYP;

  logic [W-1:0] ctl_word;
  logic [W-1:0] rd_word;
  logic         rd_sel;
  fault_e       fault;

  cpa_word_reg #(.W(W), .RST_VAL(RST_WORD)) u_word (
    .clk(clk), .rst(rst), .wr_en(nat_wr_en), .wr_data(nat_wr_data), .word(ctl_word)
  );

  cpa_decide #(.W(W), .FORCE_BIT(BIT_EXTTYP)) u_dec (
    .valid(insn_valid), .cls(insn_cls), .word(ctl_word),
    .fault(fault), .rd_sel(rd_sel), .rd_word(rd_word)
  );

  cpa_result_reg #(.W(W)) u_res (
    .clk(clk), .rst(rst), .valid(insn_valid), .fault(fault),
    .rd_sel(rd_sel), .rd_word(rd_word),
    .res_valid(res_valid), .res_fault(res_fault), .res_rdata(res_rdata)
  );
endmodule

// File: rtl/cpa_chk.sv
module cpa_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         insn_valid,
  input logic [2:0]   insn_cls,
  input logic         nat_wr_en,
  input logic [W-1:0] word,
  input logic         res_valid,
  input logic [1:0]   res_fault,
  input logic [W-1:0] res_rdata
);
  assert_valid_timing_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> res_valid == $past(insn_valid));

  assert_no_code3_R2: assert property (@(posedge clk) disable iff (rst)
    res_fault != 2'b11);

  assert_movto_intercept_R6: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_cls == 3'd4) |=> res_fault == 2'b10);

  assert_movto_keeps_word_R6: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_cls == 3'd4 && !nat_wr_en) |=> $stable(word));

  assert_simd_emul_first_R4: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_cls == 3'd2 && word[2]) |=> res_fault == 2'b10);

  assert_read_exttype_R7: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_cls == 3'd5) |=> (res_rdata[4] && res_fault == 2'b00));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_fault == 2'b00 && res_rdata == '0));
endmodule

bind cop_avail_checker cpa_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_cls(insn_cls),
  .nat_wr_en(nat_wr_en), .word(ctl_word), .res_valid(res_valid),
  .res_fault(res_fault), .res_rdata(res_rdata)
);

// File: tb/sim_cop_avail_checker.sv
module sim_cop_avail_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [2:0]  insn_cls;
  logic        nat_wr_en;
  logic [31:0] nat_wr_data;
  logic        res_valid;
  logic [1:0]  res_fault;
  logic [31:0] res_rdata;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_avail_checker u0 (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_cls(insn_cls),
    .nat_wr_en(nat_wr_en), .nat_wr_data(nat_wr_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_rdata(res_rdata)
  );

  // behavioural reference model
  logic [31:0] m_word;
  logic        m_valid;
  logic [1:0]  m_fault;
  logic [31:0] m_rdata;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_word = 32'h10; m_valid = 0; m_fault = 0; m_rdata = 0; m_tag = "R1";
    end else begin
      m_valid = insn_valid; m_fault = 2'b00; m_rdata = 0; m_tag = "R8";
      if (insn_valid) begin
        case (insn_cls)
          3'd1: begin m_tag = "R3"; if (m_word[2] || m_word[3]) m_fault = 2'b01; end
          3'd2: begin
            m_tag = "R4";
            if (m_word[2]) m_fault = 2'b10;
            else if (m_word[3]) m_fault = 2'b01;
          end
          3'd3: begin m_tag = "R5"; if (m_word[3] && m_word[1]) m_fault = 2'b01; end
          3'd4: begin m_tag = "R6"; m_fault = 2'b10; end
          3'd5: begin m_tag = "R7"; m_rdata = m_word | 32'h10; end
          default: m_tag = "R10";
        endcase
        if (nat_wr_en) m_tag = "R9";
      end
      if (nat_wr_en) m_word = nat_wr_data;
    end
  end

  always @(negedge clk) begin
    compared++;
    if (res_valid !== m_valid) begin
      mismatched++;
      $display("FAIL R2 res_valid actual=%0b expected=%0b", res_valid, m_valid);
    end
    if (res_fault !== m_fault) begin
      mismatched++;
      $display("FAIL %s res_fault actual=%02b expected=%02b", m_tag, res_fault, m_fault);
    end
    if (res_rdata !== m_rdata) begin
      mismatched++;
      $display("FAIL %s res_rdata actual=%08h expected=%08h", m_tag, res_rdata, m_rdata);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic we, input logic [31:0] wd);
    insn_valid = v; insn_cls = c; nat_wr_en = we; nat_wr_data = wd;
    @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input logic [1:0] f, input logic [31:0] d);
    #1;
    compared++;
    if (res_fault !== f || res_rdata !== d) begin
      mismatched++;
      $display("FAIL %s direct actual=%02b/%08h expected=%02b/%08h", tag, res_fault, res_rdata, f, d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    insn_valid = 0; insn_cls = 0; nat_wr_en = 0; nat_wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset word read back
    step(1, 3'd5, 0, 0);
    expect_now("R1", 2'b00, 32'h10);
    // R7: extension bit forced even when written 0
    step(0, 0, 1, 32'h0);
    step(1, 3'd5, 0, 0);
    expect_now("R7", 2'b00, 32'h10);
    // R8: write with no instruction is silent
    step(0, 0, 1, 32'hDEAD_BEE8);
    step(1, 3'd5, 0, 0);
    expect_now("R8", 2'b00, 32'hDEAD_BEF8);
    // R3/R4/R5 with TS only
    step(0, 0, 1, 32'h8);
    step(1, 3'd1, 0, 0); expect_now("R3", 2'b01, 0);
    step(1, 3'd2, 0, 0); expect_now("R4", 2'b01, 0);
    step(1, 3'd3, 0, 0); expect_now("R5", 2'b00, 0);
    step(0, 0, 1, 32'hA);
    step(1, 3'd3, 0, 0); expect_now("R5", 2'b01, 0);
    // EM only, then EM+TS priority
    step(0, 0, 1, 32'h4);
    step(1, 3'd1, 0, 0); expect_now("R3", 2'b01, 0);
    step(1, 3'd2, 0, 0); expect_now("R4", 2'b10, 0);
    step(0, 0, 1, 32'hC);
    step(1, 3'd2, 0, 0); expect_now("R4", 2'b10, 0);
    // R6: move-to traps, word unchanged
    step(1, 3'd4, 0, 0); expect_now("R6", 2'b10, 0);
    step(1, 3'd5, 0, 0); expect_now("R6", 2'b00, 32'h1C);
    // R10: other classes
    step(1, 3'd0, 0, 0); expect_now("R10", 2'b00, 0);
    step(1, 3'd7, 0, 0); expect_now("R10", 2'b00, 0);
    // R9: same-cycle write
    step(0, 0, 1, 32'h0);
    step(1, 3'd1, 1, 32'h8); expect_now("R9", 2'b00, 0);
    step(1, 3'd1, 0, 0);     expect_now("R9", 2'b01, 0);
    step(0, 0, 0, 0);
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      step(($urandom % 4) != 0, 3'($urandom % 8), ($urandom % 5) == 0, wd);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule